// File: doc/BRIEF.md
# Four-Channel Burst DMA Engine

This block moves bytes between addresses on a shared byte-wide memory bus on behalf of four independent channels. Each channel has its own source and destination base, a burst length of 1, 2, 4 or 8 bytes, a block size of up to 65536 bytes, an 8-bit repeat count and a choice of trigger input. Each trigger on the selected input asks for exactly one burst. A single engine serves the channels in turn. It copies each byte through a one-byte holding register, reading in one bus cycle and writing in the next. It uses the bus only in cycles where the CPU leaves it free.

A channel starts on the rising edge of its enable. When the enable rises with a burst length that does not divide the block size, the channel raises its error interrupt and stays idle. Completed blocks repeat until the programmed number of blocks has been moved. The channel then clears its busy flag and can raise a completion interrupt. An arbiter picks the next channel only between bursts. It works in fixed order (lowest index first) or round-robin.

Top module: `dma4_top`

## Requirements
- R1: After reset every channel is idle, every interrupt output is low, and the bus shows neither a read nor a write.
- R2: When a channel's enable rises with a valid setup, its busy flag goes high. Each trigger on that channel then moves exactly one burst of 2^code bytes, where the burst code is 0, 1, 2 or 3.
- R3: Trigger select code 0 takes the software line, code 1 the peripheral request line and code 2 the event line. Code 3 takes none. Pulses on lines that are not selected are ignored.
- R4: For block offset k, the engine reads source base + k and then writes the byte just read to destination base + k. With the bus free, the write comes in the cycle right after the read, so each byte takes two bus cycles.
- R5: The engine neither reads nor writes in any cycle where cpu_busy is high. A stalled transfer resumes later with correct data.
- R6: A block size field of 0 means 65536 bytes. The offset restarts at 0 at the start of every block. After size × repeat bytes, busy clears, irq_done rises if its enable is set, and later triggers are ignored.
- R7: A repeat count of 0 repeats the block with no limit; busy stays high until the channel is disabled.
- R8: If the enable rises while the burst length does not divide the block size, busy stays low, irq_err rises if its enable is set, and triggers cause no bus traffic.
- R9: In fixed mode (rr_mode low), the lowest-numbered channel with a pending burst wins.
- R10: In round-robin mode, the search for the next grant starts at the channel after the one granted last.
- R11: A burst in progress always finishes before any other channel gets the bus, even if a higher-priority channel triggers during it.
- R12: Taking the enable low clears busy, the pending burst and both interrupt flags. A burst whose next read has not yet been issued is dropped.
- R13: Triggers that arrive while a burst is already pending and not yet started merge into that one burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rr_mode | input | 1 | 1 = round-robin arbitration, 0 = fixed order |
| cpu_busy | input | 1 | CPU holds the bus this cycle |
| ch_en | input | NCH | Per-channel enable |
| ch_src | input | NCH*AW | Source base per channel |
| ch_dst | input | NCH*AW | Destination base per channel |
| ch_burst | input | NCH*2 | Burst code per channel (bytes = 2^code) |
| ch_blk | input | NCH*BLKW | Block size per channel (0 = 65536) |
| ch_rep | input | NCH*REPW | Blocks per transaction (0 = unlimited) |
| ch_trig_sel | input | NCH*2 | Trigger select per channel |
| ch_done_ie | input | NCH | Completion interrupt enable |
| ch_err_ie | input | NCH | Error interrupt enable |
| sw_trig | input | NCH | Software trigger pulses |
| per_req | input | NCH | Peripheral request pulses |
| evt_in | input | NCH | Event pulses |
| bus_rdata | input | DW | Read data, valid in the same cycle as bus_re |
| bus_addr | output | AW | Bus address |
| bus_re | output | 1 | Bus read strobe |
| bus_we | output | 1 | Bus write strobe |
| bus_wdata | output | DW | Bus write data |
| ch_busy | output | NCH | Channel transaction in progress |
| irq_done | output | NCH | Completion interrupt flags |
| irq_err | output | NCH | Error interrupt flags |

## Verification
The assertions assume several things about the inputs. Read data is returned in the same cycle as the read strobe. A channel's setup fields hold still while its enable is high. Triggers are single-cycle pulses. The stimulus therefore changes a channel's setup only after taking its enable low for two cycles, and drives every trigger as a one-cycle pulse shortly after a clock edge. It serves reads from a combinational function of the address, so each written byte has a known expected value. The random part toggles cpu_busy freely from cycle to cycle, since the block must accept any pattern of CPU occupancy.

// File: rtl/dma4_pkg.sv
`timescale 1ns/1ps
package dma4_pkg;
    localparam int DEF_NCH  = 4;
    localparam int DEF_AW   = 16;
    localparam int DEF_DW   = 8;
    localparam int DEF_BLKW = 16;
    localparam int DEF_REPW = 8;

    typedef enum logic [1:0] {
        TRG_SW   = 2'd0,
        TRG_PER  = 2'd1,
        TRG_EVT  = 2'd2,
        TRG_NONE = 2'd3
    } trig_sel_e;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_RD   = 2'd1,
        ENG_WR   = 2'd2
    } eng_state_e;

    function automatic logic [3:0] burst_bytes(input logic [1:0] code);
        return 4'd1 << code;
    endfunction

    // burst length does not divide the block size (size 0 = 2^BLKW always fits)
    function automatic logic burst_misfit(input logic [1:0] code, input logic [15:0] blk);
        logic [15:0] mask;
        mask = 16'(burst_bytes(code)) - 16'd1;
        return (blk & mask) != 16'd0;
    endfunction
endpackage

// File: rtl/dma4_chan.sv
`timescale 1ns/1ps
module dma4_chan
    import dma4_pkg::*;
#(
    parameter int BLKW = DEF_BLKW,
    parameter int REPW = DEF_REPW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic [1:0]      burst_code,
    input  logic [BLKW-1:0] blk,
    input  logic [REPW-1:0] rep,
    input  logic [1:0]      sel,
    input  logic            done_ie,
    input  logic            err_ie,
    input  logic            sw_trig,
    input  logic            per_req,
    input  logic            evt_in,
    input  logic            grant,
    input  logic            byte_done,
    output logic            busy,
    output logic            pending,
    output logic [BLKW-1:0] idx,
    output logic            irq_done,
    output logic            irq_err
);
    localparam int CNTW = BLKW + 1;

    logic            en_q;
    logic [REPW-1:0] blocks;
    logic [CNTW-1:0] blk_bytes;
    logic            en_rise, trig, last_byte, last_block, misfit;

    assign en_rise    = en && !en_q;
    assign blk_bytes  = (blk == '0) ? (CNTW'(1) << BLKW) : {1'b0, blk};
    assign last_byte  = ({1'b0, idx} + CNTW'(1)) == blk_bytes;
    assign last_block = (rep != '0) && ((blocks + REPW'(1)) == rep);
    assign misfit     = burst_misfit(burst_code, 16'(blk));

    always_comb begin
        case (trig_sel_e'(sel))
            TRG_SW:  trig = sw_trig;
            TRG_PER: trig = per_req;
            TRG_EVT: trig = evt_in;
            default: trig = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= 1'b0;
            busy     <= 1'b0;
            pending  <= 1'b0;
            idx      <= '0;
            blocks   <= '0;
            irq_done <= 1'b0;
            irq_err  <= 1'b0;
        end else begin
            en_q <= en;
            if (!en) begin
                busy     <= 1'b0;
                pending  <= 1'b0;
                idx      <= '0;
                blocks   <= '0;
                irq_done <= 1'b0;
                irq_err  <= 1'b0;
            end else if (en_rise) begin
                idx      <= '0;
                blocks   <= '0;
                pending  <= 1'b0;
                irq_done <= 1'b0;
                busy     <= !misfit;
                irq_err  <= misfit && err_ie;
            end else if (busy) begin
                if (trig)       pending <= 1'b1;
                else if (grant) pending <= 1'b0;
                if (byte_done) begin
                    if (last_byte) begin
                        idx <= '0;
                        if (last_block) begin
                            busy     <= 1'b0;
                            pending  <= 1'b0;
                            irq_done <= done_ie;
                        end else begin
                            blocks <= blocks + REPW'(1);
                        end
                    end else begin
                        idx <= idx + BLKW'(1);
                    end
                end
            end
        end
    end
endmodule

// File: rtl/dma4_arb.sv
`timescale 1ns/1ps
module dma4_arb #(
    parameter int NCH = 4,
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           rr_mode,
    input  logic [NCH-1:0] req,
    input  logic           take,
    output logic           gnt_valid,
    output logic [CW-1:0]  gnt_idx
);
    logic [CW-1:0] last;
    int            start;

    assign start = rr_mode ? ((int'(last) + 1) % NCH) : 0;

    always_comb begin
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        for (int k = 0; k < NCH; k++) begin
            if (!gnt_valid && req[(start + k) % NCH]) begin
                gnt_valid = 1'b1;
                gnt_idx   = CW'((start + k) % NCH);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       last <= CW'(NCH - 1);
        else if (take) last <= gnt_idx;
    end
endmodule

// File: rtl/dma4_engine.sv
`timescale 1ns/1ps
module dma4_engine
    import dma4_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = DEF_AW,
    parameter int DW  = DEF_DW,
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cpu_busy,
    input  logic          gnt_valid,
    input  logic [CW-1:0] gnt_idx,
    input  logic [1:0]    cur_burst,
    input  logic          cur_alive,
    input  logic [AW-1:0] rd_addr,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] rdata,
    output logic          take,
    output logic [CW-1:0] cur_ch,
    output logic          bus_re,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] wdata,
    output logic          byte_done
);
    eng_state_e    state;
    logic [2:0]    beat;
    logic [DW-1:0] hold;
    logic          last_beat;

    assign last_beat = beat == 3'(burst_bytes(cur_burst) - 4'd1);
    assign take      = (state == ENG_IDLE) && gnt_valid;
    assign bus_re    = (state == ENG_RD) && !cpu_busy && cur_alive;
    assign bus_we    = (state == ENG_WR) && !cpu_busy;
    assign byte_done = bus_we;
    assign bus_addr  = (state == ENG_WR) ? wr_addr : rd_addr;
    assign wdata     = hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ENG_IDLE;
            beat   <= '0;
            hold   <= '0;
            cur_ch <= '0;
        end else begin
            case (state)
                ENG_IDLE: if (gnt_valid) begin
                    cur_ch <= gnt_idx;
                    beat   <= '0;
                    state  <= ENG_RD;
                end
                ENG_RD: begin
                    if (!cur_alive) begin
                        state <= ENG_IDLE;
                    end else if (!cpu_busy) begin
                        hold  <= rdata;
                        state <= ENG_WR;
                    end
                end
                ENG_WR: if (!cpu_busy) begin
                    if (last_beat) begin
                        state <= ENG_IDLE;
                    end else begin
                        beat  <= beat + 3'd1;
                        state <= ENG_RD;
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dma4_top.sv
`timescale 1ns/1ps
module dma4_top
    import dma4_pkg::*;
#(
    parameter int NCH  = DEF_NCH,
    parameter int AW   = DEF_AW,
    parameter int DW   = DEF_DW,
    parameter int BLKW = DEF_BLKW,
    parameter int REPW = DEF_REPW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rr_mode,
    input  logic              cpu_busy,
    input  logic [NCH-1:0]    ch_en,
    input  logic [NCH*AW-1:0] ch_src,
    input  logic [NCH*AW-1:0] ch_dst,
    input  logic [NCH*2-1:0]  ch_burst,
    input  logic [NCH*BLKW-1:0] ch_blk,
    input  logic [NCH*REPW-1:0] ch_rep,
    input  logic [NCH*2-1:0]  ch_trig_sel,
    input  logic [NCH-1:0]    ch_done_ie,
    input  logic [NCH-1:0]    ch_err_ie,
    input  logic [NCH-1:0]    sw_trig,
    input  logic [NCH-1:0]    per_req,
    input  logic [NCH-1:0]    evt_in,
    input  logic [DW-1:0]     bus_rdata,
    output logic [AW-1:0]     bus_addr,
    output logic              bus_re,
    output logic              bus_we,
    output logic [DW-1:0]     bus_wdata,
    output logic [NCH-1:0]    ch_busy,
    output logic [NCH-1:0]    irq_done,
    output logic [NCH-1:0]    irq_err
);
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;

    logic [NCH-1:0]  pend, grant_v, done_v;
    logic [AW-1:0]   src_a [NCH];
    logic [AW-1:0]   dst_a [NCH];
    logic [1:0]      burst_a [NCH];
    logic [BLKW-1:0] idx_a [NCH];
    logic            gnt_valid, take, byte_done;
    logic [CW-1:0]   gnt_idx, cur_ch;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign src_a[i]   = ch_src[i*AW +: AW] + AW'(idx_a[i]);
        assign dst_a[i]   = ch_dst[i*AW +: AW] + AW'(idx_a[i]);
        assign burst_a[i] = ch_burst[i*2 +: 2];
        assign grant_v[i] = take && (gnt_idx == CW'(i));
        assign done_v[i]  = byte_done && (cur_ch == CW'(i));

        dma4_chan #(.BLKW(BLKW), .REPW(REPW)) u_chan (
            .clk        (clk),
            .rst        (rst),
            .en         (ch_en[i]),
            .burst_code (burst_a[i]),
            .blk        (ch_blk[i*BLKW +: BLKW]),
            .rep        (ch_rep[i*REPW +: REPW]),
            .sel        (ch_trig_sel[i*2 +: 2]),
            .done_ie    (ch_done_ie[i]),
            .err_ie     (ch_err_ie[i]),
            .sw_trig    (sw_trig[i]),
            .per_req    (per_req[i]),
            .evt_in     (evt_in[i]),
            .grant      (grant_v[i]),
            .byte_done  (done_v[i]),
            .busy       (ch_busy[i]),
            .pending    (pend[i]),
            .idx        (idx_a[i]),
            .irq_done   (irq_done[i]),
            .irq_err    (irq_err[i])
        );
    end

    dma4_arb #(.NCH(NCH)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .rr_mode   (rr_mode),
        .req       (pend),
        .take      (take),
        .gnt_valid (gnt_valid),
        .gnt_idx   (gnt_idx)
    );

    dma4_engine #(.NCH(NCH), .AW(AW), .DW(DW)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .cpu_busy  (cpu_busy),
        .gnt_valid (gnt_valid),
        .gnt_idx   (gnt_idx),
        .cur_burst (burst_a[cur_ch]),
        .cur_alive (ch_busy[cur_ch]),
        .rd_addr   (src_a[cur_ch]),
        .wr_addr   (dst_a[cur_ch]),
        .rdata     (bus_rdata),
        .take      (take),
        .cur_ch    (cur_ch),
        .bus_re    (bus_re),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .wdata     (bus_wdata),
        .byte_done (byte_done)
    );
endmodule

// File: rtl/dma4_checker.sv
`timescale 1ns/1ps
module dma4_checker #(
    parameter int NCH = 4,
    parameter int DW  = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           cpu_busy,
    input logic [NCH-1:0] ch_en,
    input logic           bus_re,
    input logic           bus_we,
    input logic [DW-1:0]  bus_rdata,
    input logic [DW-1:0]  bus_wdata,
    input logic [NCH-1:0] ch_busy,
    input logic [NCH-1:0] irq_err
);
    logic          last_rd;
    logic [DW-1:0] cap;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_rd <= 1'b0;
            cap     <= '0;
        end else if (bus_re) begin
            last_rd <= 1'b1;
            cap     <= bus_rdata;
        end else if (bus_we) begin
            last_rd <= 1'b0;
        end
    end

    assert_bus_yield_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_re || bus_we) |-> !cpu_busy);

    assert_single_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        bus_re |-> !bus_we);

    assert_write_follows_read_R4: assert property (@(posedge clk) disable iff (rst)
        bus_we |-> last_rd);

    assert_read_after_write_R4: assert property (@(posedge clk) disable iff (rst)
        bus_re |-> !last_rd);

    assert_write_data_R4: assert property (@(posedge clk) disable iff (rst)
        bus_we |-> (bus_wdata == cap));

    assert_disable_clears_R12: assert property (@(posedge clk) disable iff (rst)
        (ch_en != '1) |=> ((ch_busy & ~$past(ch_en)) == '0));

    assert_error_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (irq_err & ch_busy) == '0);
endmodule

bind dma4_top dma4_checker #(.NCH(NCH), .DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_busy  (cpu_busy),
    .ch_en     (ch_en),
    .bus_re    (bus_re),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .bus_wdata (bus_wdata),
    .ch_busy   (ch_busy),
    .irq_err   (irq_err)
);

// File: tb/dma4_top_bench.sv
`timescale 1ns/1ps
module dma4_top_bench;
    localparam int NCH = 4, AW = 16, DW = 8, BLKW = 16, REPW = 8;

    logic clk = 1'b0, rst = 1'b1, rr_mode = 1'b0;
    logic cpu_hold = 1'b0, rnd_busy = 1'b0, rand_on = 1'b0, cpu_busy;
    logic [NCH-1:0] ch_en = '0, done_ie = '0, err_ie = '0;
    logic [NCH-1:0] sw_trig = '0, per_req = '0, evt_in = '0;
    logic [AW-1:0]   c_src [NCH], c_dst [NCH];
    logic [1:0]      c_burst [NCH], c_sel [NCH];
    logic [BLKW-1:0] c_blk [NCH];
    logic [REPW-1:0] c_rep [NCH];
    logic [NCH*AW-1:0] ch_src, ch_dst;
    logic [NCH*2-1:0]  ch_burst, ch_sel;
    logic [NCH*BLKW-1:0] ch_blk;
    logic [NCH*REPW-1:0] ch_rep;
    logic [DW-1:0] bus_rdata, bus_wdata;
    logic [AW-1:0] bus_addr;
    logic bus_re, bus_we;
    logic [NCH-1:0] ch_busy, irq_done, irq_err;

    int n_chk = 0, n_err = 0, busy_viol = 0, rw_gap = 0;
    logic prev_re = 1'b0, finished = 1'b0;
    logic [AW-1:0] wr_a [$];
    logic [DW-1:0] wr_d [$];

    always #10 clk = ~clk;

    function automatic logic [7:0] mem_val(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    function automatic int blen(input logic [1:0] code);
        return 1 << code;
    endfunction

    assign cpu_busy  = rand_on ? rnd_busy : cpu_hold;
    assign bus_rdata = mem_val(bus_addr);

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            ch_src[i*AW +: AW]       = c_src[i];
            ch_dst[i*AW +: AW]       = c_dst[i];
            ch_burst[i*2 +: 2]       = c_burst[i];
            ch_sel[i*2 +: 2]         = c_sel[i];
            ch_blk[i*BLKW +: BLKW]   = c_blk[i];
            ch_rep[i*REPW +: REPW]   = c_rep[i];
        end
    end

    dma4_top #(.NCH(NCH), .AW(AW), .DW(DW), .BLKW(BLKW), .REPW(REPW)) u_dma4_top (
        .clk(clk), .rst(rst), .rr_mode(rr_mode), .cpu_busy(cpu_busy),
        .ch_en(ch_en), .ch_src(ch_src), .ch_dst(ch_dst), .ch_burst(ch_burst),
        .ch_blk(ch_blk), .ch_rep(ch_rep), .ch_trig_sel(ch_sel),
        .ch_done_ie(done_ie), .ch_err_ie(err_ie), .sw_trig(sw_trig),
        .per_req(per_req), .evt_in(evt_in), .bus_rdata(bus_rdata),
        .bus_addr(bus_addr), .bus_re(bus_re), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .ch_busy(ch_busy), .irq_done(irq_done),
        .irq_err(irq_err)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (bus_we) begin
                wr_a.push_back(bus_addr);
                wr_d.push_back(bus_wdata);
                if (!prev_re) rw_gap++;
            end
            if ((bus_re || bus_we) && cpu_busy) busy_viol++;
            prev_re = bus_re;
        end
    end

    always @(posedge clk) begin
        #1 rnd_busy = ($urandom % 2) == 0;
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_sw(input logic [NCH-1:0] m);
        sw_trig = m; tick(1); sw_trig = '0;
    endtask

    task automatic setup(input int ch, input logic [15:0] s, input logic [15:0] d,
                         input logic [1:0] b, input logic [15:0] blk, input logic [7:0] rep,
                         input logic [1:0] sel);
        c_src[ch] = s; c_dst[ch] = d; c_burst[ch] = b;
        c_blk[ch] = blk; c_rep[ch] = rep; c_sel[ch] = sel;
    endtask

    task automatic check_burst(input int base, input int ch, input int off, input int n,
                               input string tag);
        for (int k = 0; k < n; k++) begin
            logic [15:0] ea, sa;
            ea = c_dst[ch] + 16'(off + k);
            sa = c_src[ch] + 16'(off + k);
            if (base + k >= wr_a.size()) begin
                check(1'b0, tag, 0, ea);
            end else begin
                check(wr_a[base+k] == ea, tag, wr_a[base+k], ea);
                check(wr_d[base+k] == mem_val(sa), tag, wr_d[base+k], mem_val(sa));
            end
        end
    endtask

    // channel order by destination high byte (0x80 + channel)
    task automatic check_order(input int base, input int o0, input int o1, input int o2,
                               input int o3, input string tag);
        int ord [4];
        int pos;
        ord = '{o0, o1, o2, o3};
        pos = base;
        for (int j = 0; j < 4; j++) begin
            for (int k = 0; k < blen(c_burst[ord[j]]); k++) begin
                if (pos >= wr_a.size()) check(1'b0, tag, 0, 8'h80 + ord[j]);
                else check(wr_a[pos][15:8] == 8'(8'h80 + ord[j]), tag, wr_a[pos][15:8], 8'h80 + ord[j]);
                pos++;
            end
        end
        check(wr_a.size() == pos, tag, wr_a.size(), pos);
    endtask

    initial begin
        int base, gap0;
        void'($urandom(32'd2024));
        for (int i = 0; i < NCH; i++) setup(i, 16'h0, 16'h0, 2'd0, 16'd1, 8'd1, 2'd3);
        tick(3);
        rst = 1'b0;
        tick(1);

        // R1 reset state
        check(ch_busy == '0 && irq_done == '0 && irq_err == '0, "R1 idle after reset",
              {ch_busy, irq_done, irq_err}, 0);
        check(!bus_re && !bus_we, "R1 bus quiet", {bus_re, bus_we}, 0);

        // R2 R4 R6: 4-byte bursts, block 8, two blocks
        setup(0, 16'h1000, 16'h2000, 2'd2, 16'd8, 8'd2, 2'd0);
        done_ie[0] = 1'b1; ch_en[0] = 1'b1; tick(2);
        check(ch_busy[0], "R2 busy on enable", ch_busy[0], 1);
        gap0 = rw_gap;
        for (int b = 0; b < 4; b++) begin
            base = wr_a.size();
            pulse_sw(4'b0001); tick(20);
            check(wr_a.size() == base + 4, "R2 one burst per trigger", wr_a.size() - base, 4);
            check_burst(base, 0, (b % 2) * 4, 4, "R4 R6 burst addresses and data");
        end
        check(rw_gap == gap0, "R4 write right after read", rw_gap - gap0, 0);
        check(!ch_busy[0] && irq_done[0], "R6 completion", {ch_busy[0], irq_done[0]}, 1);
        base = wr_a.size();
        pulse_sw(4'b0001); tick(20);
        check(wr_a.size() == base, "R6 trigger after completion ignored", wr_a.size() - base, 0);

        // R3 trigger selection
        setup(1, 16'h3000, 16'h4000, 2'd0, 16'd4, 8'd1, 2'd1);
        setup(2, 16'h3100, 16'h4100, 2'd1, 16'd2, 8'd1, 2'd2);
        ch_en[2:1] = 2'b11; tick(2);
        base = wr_a.size();
        sw_trig[1] = 1'b1; evt_in[1] = 1'b1; per_req[2] = 1'b1; tick(1);
        sw_trig = '0; evt_in = '0; per_req = '0; tick(20);
        check(wr_a.size() == base, "R3 unselected lines ignored", wr_a.size() - base, 0);
        per_req[1] = 1'b1; tick(1); per_req = '0; tick(20);
        check_burst(base, 1, 0, 1, "R3 peripheral request");
        evt_in[2] = 1'b1; tick(1); evt_in = '0; tick(20);
        check_burst(base + 1, 2, 0, 2, "R3 event input");

        // R8 error, R6 block field 0
        ch_en = '0; tick(2);
        check(irq_done[0] == 1'b0, "R12 flag cleared on disable", irq_done[0], 0);
        setup(2, 16'h3200, 16'h4200, 2'd3, 16'd12, 8'd1, 2'd0);
        err_ie[2] = 1'b1; ch_en[2] = 1'b1; tick(2);
        check(!ch_busy[2] && irq_err[2], "R8 misfit raises error", {ch_busy[2], irq_err[2]}, 1);
        base = wr_a.size();
        pulse_sw(4'b0100); tick(20);
        check(wr_a.size() == base, "R8 no traffic after error", wr_a.size() - base, 0);
        setup(3, 16'h3300, 16'h4300, 2'd3, 16'd0, 8'd1, 2'd0);
        err_ie[3] = 1'b1; ch_en[3] = 1'b1; tick(2);
        check(ch_busy[3] && !irq_err[3], "R6 block field 0 accepted", {ch_busy[3], irq_err[3]}, 2);
        for (int b = 0; b < 3; b++) begin pulse_sw(4'b1000); tick(20); end
        check_burst(base, 3, 0, 24, "R6 large block offsets");
        check(ch_busy[3], "R6 large block not finished", ch_busy[3], 1);
        ch_en = '0; tick(2);

        // R7 R12 R13 unlimited repeat
        setup(0, 16'h5000, 16'h6000, 2'd1, 16'd2, 8'd0, 2'd0);
        ch_en[0] = 1'b1; tick(2);
        base = wr_a.size();
        for (int b = 0; b < 5; b++) begin pulse_sw(4'b0001); tick(12); end
        for (int b = 0; b < 5; b++) check_burst(base + 2*b, 0, 0, 2, "R7 block repeats");
        check(ch_busy[0] && !irq_done[0], "R7 still busy", {ch_busy[0], irq_done[0]}, 2);
        cpu_hold = 1'b1;
        pulse_sw(4'b0001); tick(3);
        ch_en[0] = 1'b0; tick(2);
        check(!ch_busy[0], "R12 disable clears busy", ch_busy[0], 0);
        base = wr_a.size();
        cpu_hold = 1'b0; tick(20);
        check(wr_a.size() == base, "R12 stalled burst dropped", wr_a.size() - base, 0);
        ch_en[0] = 1'b1; tick(2);
        cpu_hold = 1'b1;
        pulse_sw(4'b0001); tick(2);
        pulse_sw(4'b0001); tick(1);
        pulse_sw(4'b0001); tick(1);
        pulse_sw(4'b0001); tick(2);
        cpu_hold = 1'b0; tick(30);
        check(wr_a.size() == base + 4, "R13 pending triggers merge", wr_a.size() - base, 4);
        ch_en = '0; tick(2);

        // R9 R11 R10 arbitration
        for (int i = 0; i < NCH; i++)
            setup(i, 16'(16'h9000 + i*256), 16'(16'h8000 + i*256), (i == 3) ? 2'd3 : 2'd1,
                  16'd64, 8'd0, 2'd0);
        ch_en = '1; rr_mode = 1'b0; tick(2);
        base = wr_a.size();
        cpu_hold = 1'b1; pulse_sw(4'b1111); tick(2); cpu_hold = 1'b0; tick(50);
        check_order(base, 0, 1, 2, 3, "R9 fixed order");
        base = wr_a.size();
        pulse_sw(4'b1000); tick(4);
        pulse_sw(4'b0001); tick(30);
        check(wr_a.size() == base + 10, "R11 write count", wr_a.size() - base, 10);
        for (int k = 0; k < 10; k++)
            check(wr_a[base+k][15:8] == ((k < 8) ? 8'h83 : 8'h80), "R11 burst not split",
                  wr_a[base+k][15:8], (k < 8) ? 8'h83 : 8'h80);
        rr_mode = 1'b1;
        pulse_sw(4'b0100); tick(12);
        base = wr_a.size();
        cpu_hold = 1'b1; pulse_sw(4'b1111); tick(2); cpu_hold = 1'b0; tick(50);
        check_order(base, 3, 0, 1, 2, "R10 round robin");
        ch_en = '0; rr_mode = 1'b0; tick(2);

        // R5 random CPU occupancy with random setups
        done_ie[1] = 1'b1;
        for (int it = 0; it < 4; it++) begin
            logic [1:0] code;
            int nb, len;
            code = 2'($urandom % 4);
            nb   = 1 + int'($urandom % 3);
            len  = blen(code);
            setup(1, 16'(($urandom % 200) * 256), 16'(($urandom % 200) * 256 + 128),
                  code, 16'(len * nb), 8'd1, 2'd0);
            ch_en[1] = 1'b1; tick(2);
            base = wr_a.size();
            rand_on = 1'b1;
            for (int t = 0; t < nb; t++) begin
                pulse_sw(4'b0010);
                for (int w = 0; w < 400 && wr_a.size() < base + len*(t+1); w++) tick(1);
            end
            rand_on = 1'b0; tick(3);
            check_burst(base, 1, 0, len * nb, "R5 random stalls");
            check(!ch_busy[1] && irq_done[1], "R6 random completion", {ch_busy[1], irq_done[1]}, 1);
            ch_en[1] = 1'b0; tick(2);
        end
        check(busy_viol == 0, "R5 no access while CPU busy", busy_viol, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #3_000_000;
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule